// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects eight interrupt request lines from peripherals and presents one interrupt signal to a processor. Each line passes through a two-stage synchronizer, and a rising edge on the synchronized line marks that line as pending. A software-written mask decides which pending lines may interrupt. The block compares the best unmasked pending line with the lines already being serviced. It asserts the interrupt output only when that line outranks every line in service.

The processor answers with a one-cycle acknowledge pulse. In that cycle the block drives an 8-bit vector on its read-data bus: the programmable base plus the number of the granted line. On the same clock edge the granted line moves from pending to in service. Software reaches the block through a two-register port. Offset 0 takes commands: end-of-interrupt, and arming a load of the vector base. Offset 1 reads and writes the mask, or loads the base when a base load is armed. The interrupt output, the acknowledge vector and the readback all change in the cycle that the state changes.

Top module: `prio_intc`

## Requirements
- R1: After reset the mask reads 0xFF, no line is pending or in service, the vector base is 0x00 and `int_out` is low.
- R2: A 0-to-1 change on `irq_in[i]` makes line i pending on the third rising clock edge after the change, counted from the first edge that samples the new level. A line held high does not become pending again.
- R3: A write to offset 1 sets the mask, and a read at offset 1 returns it on `bus_rdata` in the same cycle. A mask bit of 1 keeps that line from raising `int_out`, but the line still becomes pending. Reads at offset 0 return 0x00.
- R4: `int_out` is high exactly when some pending line with a clear mask bit has a lower index than every line in service, or when no line is in service.
- R5: Priority is fixed: line 0 is highest and line 7 is lowest. A grant always goes to the lowest-indexed pending line whose mask bit is clear.
- R6: When `inta` is high while `int_out` is high, `bus_rdata` equals base + granted index in that cycle. At the next edge the granted line becomes in service and stops being pending. A new edge on the same line in that cycle keeps it pending.
- R7: Writing 0x11 to offset 0 arms a base load. The next write to offset 1 loads the vector base with bits [2:0] forced to 0 and leaves the mask unchanged. Any other write to offset 0 disarms the load.
- R8: Writing 0x20 to offset 0 removes the lowest-indexed line from the in-service set. Other values written to offset 0 leave the in-service set unchanged.
- R9: When `inta` is high while `int_out` is low, `bus_rdata` equals base + 7 and the pending and in-service sets do not change.
- R10: `inta` takes precedence over a register read in the same cycle. With neither active, `bus_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 8 | Interrupt request lines, asynchronous |
| bus_cs | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | Register offset: 0 command, 1 mask/base data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data or acknowledge vector |
| inta | input | 1 | Interrupt acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
Two lines are raised together under a mask that enables only lines 0 and 7. This checks that masked edges still become pending, that the higher line wins the grant, and that the lower line is blocked while line 0 is in service. Three lines that rise in the same cycle with the mask cleared are granted in fixed order, with an end-of-interrupt between grants. A higher line arriving while a lower one is in service shows that nesting works and that end-of-interrupt removes the most important in-service line first. A line held high after service, a spurious acknowledge, a command byte that is neither EOI nor base-arm, and an acknowledge that collides with a read each probe a case where the state must not change. A reference model compares the interrupt output and the read bus on every cycle.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int LINES   = 8;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = $clog2(LINES);
  localparam logic [DATA_W-1:0] CMD_EOI  = 8'h20;
  localparam logic [DATA_W-1:0] CMD_BASE = 8'h11;
  localparam logic PORT_CMD  = 1'b0;
  localparam logic PORT_DATA = 1'b1;
  typedef logic [LINES-1:0] line_vec_t;
  typedef logic [IDX_W-1:0] line_idx_t;
endpackage

// File: rtl/prio_intc_edge.sv
module prio_intc_edge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] rise_out
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_line
      logic meta_q, sync_q, prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b0;
          sync_q <= 1'b0;
          prev_q <= 1'b0;
        end else begin
          meta_q <= async_in[g];
          sync_q <= meta_q;
          prev_q <= sync_q;
        end
      end
      assign rise_out[g] = sync_q & ~prev_q;
    end
  endgenerate
endmodule

// File: rtl/prio_intc_find.sv
module prio_intc_find #(
  parameter int N     = 8,
  localparam int IW   = $clog2(N)
) (
  input  logic [N-1:0]  vec_in,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_in[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_in,
  input  logic              bus_cs,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              inta,
  output logic              int_out
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  line_vec_t            irr_q, irr_d, isr_q, isr_d, mask_q, mask_d, rise;
  logic [DATA_W-1:0]    base_q, base_d;
  logic                 arm_q, arm_d;
  logic                 req_found, isr_found;
  line_idx_t            req_idx, isr_idx;
  logic                 cmd_wr, data_wr, eoi_hit, ack_take;
  logic                 mask_en, base_en;

  prio_intc_edge #(.N(LINES)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .async_in(irq_in), .rise_out(rise)
  );

  prio_intc_find #(.N(LINES)) u_find_req (
    .vec_in(irr_q & ~mask_q), .found(req_found), .idx(req_idx)
  );

  prio_intc_find #(.N(LINES)) u_find_isr (
    .vec_in(isr_q), .found(isr_found), .idx(isr_idx)
  );

  assign int_out  = req_found && (!isr_found || (req_idx < isr_idx));
  assign cmd_wr   = bus_cs && bus_wr && (bus_addr == PORT_CMD);
  assign data_wr  = bus_cs && bus_wr && (bus_addr == PORT_DATA);
  assign eoi_hit  = cmd_wr && (bus_wdata == CMD_EOI);
  assign ack_take = inta && int_out;
  assign mask_en  = data_wr && !arm_q;
  assign base_en  = data_wr && arm_q;

  // next-state
  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    if (eoi_hit && isr_found) isr_d[isr_idx] = 1'b0;
    if (ack_take) begin
      isr_d[req_idx] = 1'b1;
      irr_d[req_idx] = 1'b0;
    end
    irr_d = irr_d | rise;

    mask_d = mask_en ? bus_wdata : mask_q;
    base_d = base_en ? {bus_wdata[DATA_W-1:IDX_W], {IDX_W{1'b0}}} : base_q;

    arm_d = arm_q;
    if (cmd_wr)       arm_d = (bus_wdata == CMD_BASE);
    else if (base_en) arm_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      mask_q <= '1;
      base_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      arm_q <= arm_d;
      if (mask_en) mask_q <= mask_d;
      if (base_en) base_q <= base_d;
    end
  end

  // read / vector path
  always_comb begin
    if (inta)
      bus_rdata = base_q + DATA_W'(int_out ? req_idx : line_idx_t'(LINES - 1));
    else if (bus_cs && bus_rd && (bus_addr == PORT_DATA))
      bus_rdata = mask_q;
    else
      bus_rdata = '0;
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
  import prio_intc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              int_out,
  input logic              inta,
  input logic [DATA_W-1:0] bus_rdata,
  input line_vec_t         irr_q,
  input line_vec_t         isr_q,
  input line_vec_t         mask_q,
  input logic [DATA_W-1:0] base_q,
  input logic              eoi_hit
);
  // R3 / R4: the output needs an unmasked pending line behind it
  p_int_needs_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr_q & ~mask_q) != '0));

  // R6: a taken acknowledge adds exactly one in-service line
  p_ack_adds_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_out && !eoi_hit) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));

  // R8: end-of-interrupt removes exactly one in-service line
  p_eoi_drops_isr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && isr_q != '0 && !(inta && int_out)) |=>
      ($countones(isr_q) == $past($countones(isr_q)) - 1));

  // R7: the base keeps its low three bits clear
  p_base_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[IDX_W-1:0] == '0);

  // R6 / R9: the vector carries the base in its upper bits
  p_vector_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inta |-> (bus_rdata[DATA_W-1:IDX_W] == base_q[DATA_W-1:IDX_W]));

  // R9: a spurious acknowledge leaves the in-service set alone
  p_spurious_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out && !eoi_hit) |=> $stable(isr_q));
endmodule

bind prio_intc prio_intc_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .int_out(int_out), .inta(inta),
  .bus_rdata(bus_rdata), .irr_q(irr_q), .isr_q(isr_q), .mask_q(mask_q),
  .base_q(base_q), .eoi_hit(eoi_hit)
);

// File: tb/prio_intc_tb_top.sv
module prio_intc_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       bus_cs, bus_wr, bus_rd, bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       inta, int_out;

  int errors = 0;
  int checks = 0;
  string phase = "R1";

  always #2 clk = ~clk;   // 250 MHz

  prio_intc dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_cs(bus_cs), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .inta(inta), .int_out(int_out)
  );

  // ---------------- reference model ----------------
  bit   m_pend[8];
  bit   m_serv[8];
  bit   m_mask[8];
  int   m_base;
  bit   m_arm;
  bit [7:0] hist[$];

  function automatic int best_req();
    for (int i = 0; i < 8; i++) if (m_pend[i] && !m_mask[i]) return i;
    return -1;
  endfunction

  function automatic int best_serv();
    for (int i = 0; i < 8; i++) if (m_serv[i]) return i;
    return 8;
  endfunction

  function automatic bit exp_int();
    int r = best_req();
    return (r >= 0) && (r < best_serv());
  endfunction

  function automatic int exp_rdata();
    int m = 0;
    if (inta) return (m_base + (exp_int() ? best_req() : 7)) & 255;
    if (bus_cs && bus_rd && bus_addr) begin
      for (int i = 0; i < 8; i++) if (m_mask[i]) m = m + (1 << i);
      return m;
    end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_pend[i] = 0; m_serv[i] = 0; m_mask[i] = 1;
      end
      m_base = 0; m_arm = 0;
      hist = '{8'h00, 8'h00, 8'h00};
    end else begin
      bit [7:0] rise;
      int r, s;
      rise = hist[1] & ~hist[2];
      r = best_req();
      s = best_serv();
      if (bus_cs && bus_wr && !bus_addr && bus_wdata == 8'h20 && s < 8) m_serv[s] = 0;
      if (inta && exp_int()) begin
        m_serv[r] = 1; m_pend[r] = 0;
      end
      for (int i = 0; i < 8; i++) if (rise[i]) m_pend[i] = 1;
      if (bus_cs && bus_wr && bus_addr) begin
        if (m_arm) begin
          m_base = bus_wdata & 8'hF8; m_arm = 0;
        end else begin
          for (int i = 0; i < 8; i++) m_mask[i] = bus_wdata[i];
        end
      end else if (bus_cs && bus_wr && !bus_addr) begin
        m_arm = (bus_wdata == 8'h11);
      end
      hist.push_front(irq_in);
      void'(hist.pop_back());
    end
  end

  // compare every cycle, away from the edges
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      checks++;
      if (int_out !== exp_int()) begin
        errors++;
        $display("FAIL %s int_out actual=%0b expected=%0b at %0t", phase, int_out, exp_int(), $time);
      end
      checks++;
      if (bus_rdata !== 8'(exp_rdata())) begin
        errors++;
        $display("FAIL %s bus_rdata actual=%02h expected=%02h at %0t", phase, bus_rdata, exp_rdata(), $time);
      end
    end
  end

  // targeted check against a value worked out from the requirements
  task automatic expect_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit a, input int d);
    @(negedge clk);
    bus_cs = 1; bus_wr = 1; bus_addr = a; bus_wdata = 8'(d);
    @(negedge clk);
    bus_cs = 0; bus_wr = 0;
  endtask

  task automatic rd_mask(input string tag, input int exp);
    @(negedge clk);
    bus_cs = 1; bus_rd = 1; bus_addr = 1;
    #1 expect_val(tag, bus_rdata, exp);
    @(negedge clk);
    bus_cs = 0; bus_rd = 0;
  endtask

  task automatic ack(input string tag, input int exp_vec);
    @(negedge clk);
    inta = 1;
    #1 expect_val(tag, bus_rdata, exp_vec);
    @(negedge clk);
    inta = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; irq_in = 0; bus_cs = 0; bus_wr = 0; bus_rd = 0;
    bus_addr = 0; bus_wdata = 0; inta = 0;
    idle(3);
    rst_n = 1;
    idle(4);

    phase = "R1";
    expect_val("R1 int_out", int_out, 0);
    rd_mask("R1 mask reset", 8'hFF);

    phase = "R7";
    wr(0, 8'h11);
    wr(1, 8'h27);
    rd_mask("R7 mask unchanged", 8'hFF);
    wr(0, 8'h11);
    wr(0, 8'h05);        // disarms
    wr(1, 8'hFF);        // goes to mask
    rd_mask("R7 disarm", 8'hFF);

    phase = "R3";
    wr(1, 8'h7E);
    rd_mask("R3 readback", 8'h7E);
    @(negedge clk); bus_cs = 1; bus_rd = 1; bus_addr = 0;
    #1 expect_val("R3 offset0 read", bus_rdata, 0);
    @(negedge clk); bus_cs = 0; bus_rd = 0;

    phase = "R2";
    @(negedge clk); irq_in = 8'b1000_1001;   // lines 0,3,7; 3 masked
    idle(1);
    expect_val("R2 not yet", int_out, 0);
    idle(2);
    expect_val("R2 pending", int_out, 1);

    phase = "R6";
    ack("R6 vector line0", 8'h20);
    expect_val("R4 line7 blocked", int_out, 0);
    phase = "R8";
    wr(0, 8'h20);
    expect_val("R8 line7 free", int_out, 1);
    phase = "R6";
    ack("R6 vector line7", 8'h27);
    phase = "R8";
    wr(0, 8'h33);        // not an EOI
    expect_val("R8 other cmd", int_out, 0);
    wr(0, 8'h20);
    phase = "R2";
    idle(4);
    expect_val("R2 held level", int_out, 0);

    phase = "R9";
    ack("R9 spurious", 8'h27);
    expect_val("R9 no change", int_out, 0);

    phase = "R5";
    @(negedge clk); irq_in = 0;
    idle(3);
    wr(1, 8'h00);
    expect_val("R3 masked line3 pending", int_out, 1);
    ack("R5 line3", 8'h23);
    wr(0, 8'h20);
    @(negedge clk); irq_in = 8'b0110_0100;    // lines 2,5,6
    idle(4);
    ack("R5 first", 8'h22);
    wr(0, 8'h20);
    ack("R5 second", 8'h25);

    phase = "R4";
    @(negedge clk); irq_in = 8'b0000_0010;    // line 1 nests over 5
    idle(4);
    expect_val("R4 nest", int_out, 1);
    ack("R4 nested vector", 8'h21);
    wr(0, 8'h20);        // clears 1, 5 still in service
    expect_val("R8 lowest first", int_out, 0);
    wr(0, 8'h20);        // clears 5
    expect_val("R5 line6 now", int_out, 1);

    phase = "R10";
    @(negedge clk);
    inta = 1; bus_cs = 1; bus_rd = 1; bus_addr = 1;
    #1 expect_val("R10 inta wins", bus_rdata, 8'h26);
    @(negedge clk);
    inta = 0; bus_cs = 0; bus_rd = 0;
    wr(0, 8'h20);
    idle(2);
    expect_val("R10 idle bus", bus_rdata, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule